// File: doc/BRIEF.md
# Frame-Based Sample Acquisition Controller

This block fills a byte-wide buffer RAM with flash-converter samples. It splits the acquisition into frames of six or eight bytes. A host loads a divisor, a starting frame number and a frame count through a small register write port. Acquisition is then started in one of two ways: by a host command write, or by an external start strobe when external control is selected. While a run is active, the block divides the base clock into a square sample clock. On each sample clock rising point it writes one sample into the RAM, at the current frame and byte position. When the programmed number of frames has been stored, it stops.

The status output `acquire` is high for the whole of a run. `acq_event` is its inverse and serves as the completion event towards the host. The current frame number can be read back at any time. During a run it advances by one after the last byte of every frame, and it wraps from 8191 to 0.

Register select codes on `reg_sel`:
- 0: configuration. Bits [4:0] hold the divisor, bit 5 selects six-byte frames and bit 6 enables external start.
- 1: starting frame number, bits [12:0].
- 2: frame count, bits [15:0].
- 3: start command (the data is ignored).

Writes to codes 0, 1 and 2 take effect only while idle.

The controller has two states:
- IDLE. Transition ARM leads to RUN when a start request arrives with a non-zero count.
- RUN. Transition FINISH leads back to IDLE on the write of the last byte of the frame that brings the count from 1 to 0.

A start request with a zero count takes transition REJECT, which stays in IDLE.

Top module: `acq_frame_ctrl`

## Requirements
- R1: After reset, `acquire`, `ram_we` and `smp_clk` are 0, `acq_event` is 1 and `frame_addr_rd` is 0.
- R2: During a run, with divisor D equal to the configuration field clamped to the range 2..16, `smp_clk` is low for the first D cycles of the run. After that it alternates D cycles high and D cycles low. Consecutive RAM writes are exactly 2·D cycles apart. `smp_clk` is 0 while idle.
- R3: Each write occurs in the cycle in which `smp_clk` is about to rise. It places `smp_data` of that cycle at `ram_addr` = {frame[12:0], byte[2:0]}, and the byte index starts at 0 at the start of a run. `ram_we` is never high outside a run.
- R4: With configuration bit 5 set, only byte indices 0..5 of each frame are written. Otherwise indices 0..7 are written.
- R5: The frame number advances by one, modulo 8192, right after the last byte of each frame. `frame_addr_rd` shows it at all times.
- R6: A run with count N performs exactly N·(bytes per frame) writes. `acquire` falls in the cycle after the final write.
- R7: `acq_event` is always the inverse of `acquire`.
- R8: With configuration bit 6 set, only a high `ext_start` starts a run. With it clear, only a write to select code 3 starts a run.
- R9: A start request while `acquire` is high has no effect on the ongoing run.
- R10: A start request with a frame count of 0 writes nothing and leaves `acquire` low.
- R11: Register writes to select codes 0, 1 and 2 during a run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select code |
| reg_wdata | input | 16 | Register write data |
| ext_start | input | 1 | External start strobe |
| smp_data | input | 8 | Converter sample |
| frame_addr_rd | output | 13 | Current frame number |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_addr | output | 16 | Buffer RAM byte address |
| ram_wdata | output | 8 | Buffer RAM write data |
| smp_clk | output | 1 | Divided sample clock |
| acquire | output | 1 | Run in progress |
| acq_event | output | 1 | Completion event, inverse of acquire |

## Verification
The bench targets several corner cases:
- Divisor values below 2 and above 16. A missing clamp shows up as write spacing other than 4 or 32 cycles.
- The frame number wrapping from 8191 to 0. A wrong width or missing wrap would write out-of-range frames or read back the wrong number.
- Six-byte frames. Stepping to index 6 or 7 would add writes and shift later frames.
- A zero count. An unguarded decrement would underflow and run for 65536 frames.
- Host command, register writes and external strobe arriving while busy, or from the unselected source. A design that honoured them would restart the run, change the write total or the frame number, or start when it should not.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } acq_state_e;

    localparam logic [1:0] SEL_CFG   = 2'd0;
    localparam logic [1:0] SEL_FRAME = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_GO    = 2'd3;

    localparam int CFG_SIX_BIT = 5;
    localparam int CFG_EXT_BIT = 6;

    typedef struct packed {
        logic       ext_en;
        logic       six;
        logic [4:0] div;
    } acq_cfg_t;

endpackage

// File: rtl/acq_rate_gen.sv
module acq_rate_gen #(
    parameter int DIV_W   = 5,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             smp_clk,
    output logic             smp_en
);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic             wrap;

    // Clamp the programmed divisor into the legal range.
    always_comb begin
        if (div_sel < DIV_W'(DIV_MIN)) begin
            eff = DIV_W'(DIV_MIN);
        end else if (div_sel > DIV_W'(DIV_MAX)) begin
            eff = DIV_W'(DIV_MAX);
        end else begin
            eff = div_sel;
        end
    end

    assign wrap = (cnt_q == eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The fixed divide by two gives a square clock; enable on the rising half.
    assign smp_en  = run & wrap & ~phase_q;
    assign smp_clk = run & phase_q;

endmodule

// File: rtl/acq_frame_track.sv
module acq_frame_track #(
    parameter int FRAME_AW    = 13,
    parameter int BYTE_AW     = 3,
    parameter int CNT_W       = 16,
    parameter int SHORT_BYTES = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_frame,
    input  logic                ld_count,
    input  logic [CNT_W-1:0]    ld_val,
    input  logic                arm,
    input  logic                step,
    input  logic                six_mode,
    output logic [FRAME_AW-1:0] frame_q,
    output logic [BYTE_AW-1:0]  byte_q,
    output logic                frame_end,
    output logic                cnt_last,
    output logic                cnt_zero
);

    localparam int FULL_BYTES = 2 ** BYTE_AW;

    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_AW-1:0] last_idx;

    assign last_idx  = six_mode ? BYTE_AW'(SHORT_BYTES - 1) : BYTE_AW'(FULL_BYTES - 1);
    assign frame_end = (byte_q == last_idx);
    assign cnt_last  = (cnt_q == CNT_W'(1));
    assign cnt_zero  = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            byte_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (ld_frame) begin
                frame_q <= ld_val[FRAME_AW-1:0];
            end
            if (ld_count) begin
                cnt_q <= ld_val;
            end
            if (arm) begin
                byte_q <= '0;
            end else if (step) begin
                if (frame_end) begin
                    byte_q  <= '0;
                    frame_q <= frame_q + 1'b1;
                    cnt_q   <= cnt_q - 1'b1;
                end else begin
                    byte_q <= byte_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/acq_frame_ctrl.sv
module acq_frame_ctrl
    import acq_pkg::*;
#(
    parameter int FRAME_AW    = 13,
    parameter int BYTE_AW     = 3,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 5,
    parameter int DIV_MIN     = 2,
    parameter int DIV_MAX     = 16,
    parameter int SHORT_BYTES = 6,
    localparam int ADDR_W     = FRAME_AW + BYTE_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [CNT_W-1:0]    reg_wdata,
    input  logic                ext_start,
    input  logic [DATA_W-1:0]   smp_data,
    output logic [FRAME_AW-1:0] frame_addr_rd,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                smp_clk,
    output logic                acquire,
    output logic                acq_event
);

    acq_state_e        state_q, state_d;
    acq_cfg_t          cfg_q;
    logic              idle;
    logic              host_wr;
    logic              start_req;
    logic              arm;
    logic              smp_en;
    logic              running;
    logic [BYTE_AW-1:0] byte_q;
    logic              frame_end;
    logic              cnt_last;
    logic              cnt_zero;

    assign idle    = (state_q == ST_IDLE);
    assign running = (state_q == ST_RUN);
    assign host_wr = reg_we & idle;

    // Exactly one start source is honoured, picked by the configuration.
    assign start_req = idle & (cfg_q.ext_en ? ext_start : (reg_we && reg_sel == SEL_GO));
    assign arm       = start_req & ~cnt_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (host_wr && reg_sel == SEL_CFG) begin
            cfg_q.div    <= reg_wdata[DIV_W-1:0];
            cfg_q.six    <= reg_wdata[CFG_SIX_BIT];
            cfg_q.ext_en <= reg_wdata[CFG_EXT_BIT];
        end
    end

    acq_rate_gen #(
        .DIV_W  (DIV_W),
        .DIV_MIN(DIV_MIN),
        .DIV_MAX(DIV_MAX)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .div_sel(cfg_q.div),
        .smp_clk(smp_clk),
        .smp_en (smp_en)
    );

    acq_frame_track #(
        .FRAME_AW   (FRAME_AW),
        .BYTE_AW    (BYTE_AW),
        .CNT_W      (CNT_W),
        .SHORT_BYTES(SHORT_BYTES)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_frame (host_wr && reg_sel == SEL_FRAME),
        .ld_count (host_wr && reg_sel == SEL_COUNT),
        .ld_val   (reg_wdata),
        .arm      (arm),
        .step     (smp_en),
        .six_mode (cfg_q.six),
        .frame_q  (frame_addr_rd),
        .byte_q   (byte_q),
        .frame_end(frame_end),
        .cnt_last (cnt_last),
        .cnt_zero (cnt_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ARM, REJECT (zero count stays idle), FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (smp_en && frame_end && cnt_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acquire   = running;
        acq_event = ~running;
        ram_we    = smp_en;
        ram_addr  = {frame_addr_rd, byte_q};
        ram_wdata = smp_data;
    end

endmodule

// File: rtl/acq_frame_ctrl_chk.sv
module acq_frame_ctrl_chk #(
    parameter int FRAME_AW = 13,
    parameter int BYTE_AW  = 3,
    localparam int ADDR_W  = FRAME_AW + BYTE_AW
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acquire,
    input logic                acq_event,
    input logic                ram_we,
    input logic [ADDR_W-1:0]   ram_addr,
    input logic                smp_clk,
    input logic [FRAME_AW-1:0] frame_addr_rd,
    input logic                six_mode,
    input logic                cnt_zero
);

    logic [BYTE_AW-1:0] last_idx;
    assign last_idx = six_mode ? BYTE_AW'(5) : {BYTE_AW{1'b1}};

    assert_event_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acq_event == !acquire);

    assert_write_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> acquire);

    assert_short_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && six_mode) |-> (ram_addr[BYTE_AW-1:0] <= BYTE_AW'(5)));

    assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acquire |-> !smp_clk);

    assert_hold_until_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acquire && !ram_we) |=> acquire);

    assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acquire && cnt_zero) |=> !acquire);

    assert_frame_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[BYTE_AW-1:0] == last_idx)
        |=> frame_addr_rd == $past(ram_addr[ADDR_W-1:BYTE_AW]) + 1'b1);

endmodule

bind acq_frame_ctrl acq_frame_ctrl_chk #(
    .FRAME_AW(FRAME_AW),
    .BYTE_AW (BYTE_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acquire      (acquire),
    .acq_event    (acq_event),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr),
    .smp_clk      (smp_clk),
    .frame_addr_rd(frame_addr_rd),
    .six_mode     (cfg_q.six),
    .cnt_zero     (cnt_zero)
);

// File: tb/test_acq_frame_ctrl.sv
module test_acq_frame_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        ext_start = 1'b0;
    logic [7:0]  smp_data = 8'd0;
    logic [12:0] frame_addr_rd;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        smp_clk;
    logic        acquire;
    logic        acq_event;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    bit expect_wr = 0;
    int dval = 2;
    int nbytes = 8;
    int exp_frame = 0;
    int exp_byte = 0;
    int wr_run = 0;
    int run_total = 0;
    int since = 0;

    acq_frame_ctrl i_acq_frame_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .ext_start    (ext_start),
        .smp_data     (smp_data),
        .frame_addr_rd(frame_addr_rd),
        .ram_we       (ram_we),
        .ram_addr     (ram_addr),
        .ram_wdata    (ram_wdata),
        .smp_clk      (smp_clk),
        .acquire      (acquire),
        .acq_event    (acq_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: checks every write, the sample clock shape and the event pin.
    initial begin
        forever begin
            @(negedge clk);
            since++;
            if (rst_n) begin
                chk(acq_event == !acquire, "R7", "event vs acquire", acq_event, !acquire);
                if (acquire) begin
                    chk(smp_clk == (wr_run > 0 && since >= 1 && since <= dval), "R2",
                        "smp_clk level", smp_clk, (wr_run > 0 && since >= 1 && since <= dval));
                end
                if (run_total > 0 && wr_run == run_total && since == 1) begin
                    chk(!acquire, "R6", "acquire after final write", acquire, 0);
                end
                if (ram_we) begin
                    if (!expect_wr) begin
                        chk(0, "R3", "unexpected write addr", ram_addr, -1);
                    end else begin
                        chk(ram_addr == 16'((exp_frame << 3) + exp_byte), "R3",
                            "write address", ram_addr, (exp_frame << 3) + exp_byte);
                        chk(ram_wdata == smp_data, "R3", "write data", ram_wdata, smp_data);
                        if (wr_run > 0) begin
                            chk(since == 2 * dval, "R2", "write spacing", since, 2 * dval);
                        end
                        exp_byte++;
                        if (exp_byte == nbytes) begin
                            exp_byte = 0;
                            exp_frame = (exp_frame + 1) % 8192;
                        end
                    end
                    wr_run++;
                    since = 0;
                end
            end
            smp_data = smp_data + 8'd37;
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic configure(input int div, input bit six, input bit ext,
                             input int start, input int count);
        reg_write(2'd0, 16'((int'(ext) << 6) | (int'(six) << 5) | (div & 31)));
        reg_write(2'd1, 16'(start));
        reg_write(2'd2, 16'(count));
        dval = (div < 2) ? 2 : (div > 16 ? 16 : div);
        nbytes = six ? 6 : 8;
        exp_frame = start;
        exp_byte = 0;
        wr_run = 0;
        run_total = count * nbytes;
    endtask

    task automatic pulse_ext();
        @(negedge clk);
        ext_start = 1'b1;
        @(negedge clk);
        ext_start = 1'b0;
    endtask

    task automatic finish_run(input string req, input int start, input int count);
        int limit;
        limit = count * nbytes * 2 * dval + 100;
        for (int i = 0; i < limit && acquire; i++) @(negedge clk);
        chk(!acquire, req, "run ended", acquire, 0);
        chk(wr_run == count * nbytes, req, "write total", wr_run, count * nbytes);
        chk(frame_addr_rd == 13'((start + count) % 8192), "R5", "frame readback",
            frame_addr_rd, (start + count) % 8192);
        expect_wr = 0;
        run_total = 0;
    endtask

    task automatic host_run(input int div, input bit six, input int start,
                            input int count, input string req);
        configure(div, six, 1'b0, start, count);
        expect_wr = 1;
        reg_write(2'd3, 16'd0);
        chk(acquire == 1'b1, "R8", "host start raises acquire", acquire, 1);
        finish_run(req, start, count);
    endtask

    task automatic t_reset();
        chk(acquire == 1'b0, "R1", "acquire", acquire, 0);
        chk(acq_event == 1'b1, "R1", "acq_event", acq_event, 1);
        chk(ram_we == 1'b0, "R1", "ram_we", ram_we, 0);
        chk(smp_clk == 1'b0, "R1", "smp_clk", smp_clk, 0);
        chk(frame_addr_rd == 13'd0, "R1", "frame", frame_addr_rd, 0);
    endtask

    task automatic t_basic();   // R3 R6 eight-byte frames, D=3
        host_run(3, 1'b0, 5, 2, "R6");
    endtask

    task automatic t_six();     // R4 six-byte frames
        host_run(2, 1'b1, 100, 3, "R4");
    endtask

    task automatic t_clamp();   // R2 divisor clamping
        host_run(0, 1'b0, 20, 1, "R2");
        host_run(31, 1'b0, 30, 1, "R2");
    endtask

    task automatic t_wrap();    // R5 wrap past 8191
        host_run(2, 1'b0, 8190, 3, "R5");
    endtask

    task automatic t_zero();    // R10
        configure(2, 1'b0, 1'b0, 77, 0);
        expect_wr = 0;
        reg_write(2'd3, 16'd0);
        repeat (20) @(negedge clk);
        chk(!acquire, "R10", "acquire with zero count", acquire, 0);
        chk(wr_run == 0, "R10", "writes with zero count", wr_run, 0);
        chk(frame_addr_rd == 13'd77, "R10", "frame unchanged", frame_addr_rd, 77);
    endtask

    task automatic t_ext();     // R8
        configure(2, 1'b0, 1'b1, 10, 1);
        expect_wr = 0;
        reg_write(2'd3, 16'd0);
        repeat (20) @(negedge clk);
        chk(!acquire, "R8", "host start ignored in ext mode", acquire, 0);
        chk(wr_run == 0, "R8", "no writes from host start", wr_run, 0);
        expect_wr = 1;
        pulse_ext();
        chk(acquire, "R8", "ext strobe starts", acquire, 1);
        finish_run("R8", 10, 1);
        configure(2, 1'b0, 1'b0, 50, 1);
        expect_wr = 0;
        pulse_ext();
        repeat (20) @(negedge clk);
        chk(!acquire, "R8", "ext strobe ignored in host mode", acquire, 0);
        chk(wr_run == 0, "R8", "no writes from ext strobe", wr_run, 0);
    endtask

    task automatic t_busy();    // R9 R11
        configure(2, 1'b0, 1'b0, 40, 2);
        expect_wr = 1;
        reg_write(2'd3, 16'd0);
        repeat (5) @(negedge clk);
        reg_write(2'd1, 16'd0);       // R11 frame write while busy
        reg_write(2'd2, 16'd50);      // R11 count write while busy
        reg_write(2'd0, 16'd16);      // R11 config write while busy
        reg_write(2'd3, 16'd0);       // R9 restart while busy
        finish_run("R9", 40, 2);
        chk(wr_run == 16, "R11", "busy writes ignored total", wr_run, 16);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_six();
        t_clamp();
        t_wrap();
        t_zero();
        t_ext();
        t_busy();
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule